// File: doc/BRIEF.md
# Endian-Configurable Byte/Word Load-Store Unit

This unit sits between a simple processor-side request port and a 32-bit, byte-addressed data memory. Each request names a byte or a word access, a read or a write, and any byte address. The unit turns the request into one or two aligned word accesses. It places or gathers the bytes according to a byte-order mode. It then reports completion with a one-cycle done pulse, an error flag and the load data.

The byte order is taken from a strap input once after reset and then held. A word access whose address is not a multiple of four is handled by a per-request strictness input. In strict mode it is refused with an error and no memory write. In permissive mode it is split across the two aligned words it touches: stores use complementary byte enables, and loads merge the two responses.

Memory lane convention: on `mem_addr_o` (always a multiple of 4), lane k (bits 8k+7:8k) of `mem_wdata_o`, `mem_rdata_i` and bit k of `mem_be_o` refer to the byte at address `mem_addr_o + k`.

Top module: `endian_ldst_unit`

## Requirements
- R1: The byte order is sampled from `boot_big_i` at the first rising clock edge after `rst_n` goes high, and `req_ready_o` stays low until then. Later changes of `boot_big_i` have no effect until the next reset.
- R2: In little-endian order (`boot_big_i`=0), a word value V at address A puts V[8i+7:8i] in byte A+i, for i = 0..3. A word load reads the bytes back the same way.
- R3: In big-endian order (`boot_big_i`=1), a word value V at address A puts V[8i+7:8i] in byte A+3-i. A word load reads the bytes back the same way.
- R4: A byte store writes `req_wdata_i[7:0]` to address A with exactly one byte enable set, on lane A mod 4. The other bytes of that word are unchanged.
- R5: A byte load returns the byte at address A in `load_data_o[7:0]`, with bits 31:8 zero.
- R6: An aligned access, or any byte access, makes exactly one memory access. `done_o` pulses in the cycle after the memory response, which gives 3 cycles from acceptance with a one-cycle memory.
- R7: With `strict_align_i`=1, a word access at an address with A mod 4 ≠ 0 makes no memory access and writes nothing. `done_o` and `err_o` pulse together in the cycle after acceptance.
- R8: With `strict_align_i`=0, a misaligned word access makes two accesses, first at 4·floor(A/4) and then at the next word, with the address wrapping at the top of the address space. `done_o` pulses only in the cycle after the second response.
- R9: A split word store drives byte enables on the second access that are the bitwise complement of those on the first.
- R10: A split word load merges bytes from both responses into a value ordered per R2/R3.
- R11: `req_ready_o` is low while an access is in progress; no request is taken then. `err_o` is never high without `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boot_big_i | input | 1 | Byte-order strap: 1 = big-endian, 0 = little-endian |
| strict_align_i | input | 1 | 1 = refuse misaligned word accesses, 0 = split them |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_word_i | input | 1 | 1 = word access, 0 = byte access |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 32 | Store data (byte stores use bits 7:0) |
| req_ready_o | output | 1 | Unit can take a request |
| mem_req_o | output | 1 | Memory access strobe (one cycle per access) |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | ADDR_W | Word-aligned memory address |
| mem_be_o | output | 4 | Byte enables per lane |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rvalid_i | input | 1 | Memory response strobe |
| mem_rdata_i | input | 32 | Memory read data |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Alignment error, valid with done_o |
| load_data_o | output | 32 | Load result, valid with done_o |

## Verification
The bench sweeps every byte address of a 64-byte memory with byte and word stores, each followed by a load from the same address. It repeats the sweep under all four combinations of byte order and strictness. The strap input is inverted right after it is sampled, which separates a latched mode from a live one. Aligned, misaligned and top-of-memory wrapping addresses separate the single, split and refused paths by latency, access count and result. After every store the whole memory image is compared, which shows stray byte-enable writes and writes from refused accesses.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int LANES  = 4;
  localparam int DATA_W = 8 * LANES;

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE1, S_WAIT1, S_ISSUE2, S_WAIT2
  } lsu_state_e;

  // Place store bytes over two consecutive words (lanes 0..7).
  function automatic logic [2*DATA_W-1:0] spread_data(logic [DATA_W-1:0] v,
      logic [1:0] off, logic word, logic big);
    logic [2*DATA_W-1:0] d;
    int p, s;
    d = '0;
    for (int i = 0; i < LANES; i++) begin
      if (word || i == 0) begin
        p = int'(off) + i;
        s = (word && big) ? (LANES - 1 - i) : i;
        d[p*8 +: 8] = v[s*8 +: 8];
      end
    end
    return d;
  endfunction

  function automatic logic [2*LANES-1:0] spread_be(logic [1:0] off, logic word);
    logic [2*LANES-1:0] be;
    be = '0;
    for (int i = 0; i < LANES; i++)
      if (word || i == 0) be[int'(off) + i] = 1'b1;
    return be;
  endfunction

  // Gather load bytes from two consecutive words.
  function automatic logic [DATA_W-1:0] collect(logic [2*DATA_W-1:0] pair,
      logic [1:0] off, logic word, logic big);
    logic [DATA_W-1:0] r;
    int p, s;
    r = '0;
    for (int i = 0; i < LANES; i++) begin
      if (word || i == 0) begin
        p = int'(off) + i;
        s = (word && big) ? (LANES - 1 - i) : i;
        r[s*8 +: 8] = pair[p*8 +: 8];
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/lsu_mode_latch.sv
module lsu_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_i,
  output logic big_o,
  output logic seen_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      big_o  <= 1'b0;
      seen_o <= 1'b0;
    end else if (!seen_o) begin
      big_o  <= mode_i;
      seen_o <= 1'b1;
    end
  end

  p_mode_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    seen_o |=> $stable(big_o));
endmodule

// File: rtl/lsu_store_pack.sv
module lsu_store_pack import lsu_pkg::*; (
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [1:0]          off_i,
  input  logic                word_i,
  input  logic                big_i,
  output logic [2*DATA_W-1:0] data_o,
  output logic [2*LANES-1:0]  be_o
);
  always_comb begin
    data_o = spread_data(wdata_i, off_i, word_i, big_i);
    be_o   = spread_be(off_i, word_i);
  end
endmodule

// File: rtl/lsu_load_merge.sv
module lsu_load_merge import lsu_pkg::*; (
  input  logic [DATA_W-1:0] lo_i,
  input  logic [DATA_W-1:0] hi_i,
  input  logic [1:0]        off_i,
  input  logic              word_i,
  input  logic              big_i,
  output logic [DATA_W-1:0] data_o
);
  always_comb data_o = collect({hi_i, lo_i}, off_i, word_i, big_i);
endmodule

// File: rtl/endian_ldst_unit.sv
module endian_ldst_unit import lsu_pkg::*; #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_big_i,
  input  logic              strict_align_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_word_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [LANES-1:0]  mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic [DATA_W-1:0] load_data_o
);
  localparam int WIDX_W = ADDR_W - 2;

  lsu_state_e          state_q;
  logic                big_q, mode_seen;
  logic                write_q, word_q, split_q;
  logic [1:0]          off_q;
  logic [WIDX_W-1:0]   widx_q, widx_next;
  logic [DATA_W-1:0]   wdata_q, lo_rd_q, merged, lo_sel;
  logic [2*DATA_W-1:0] pack_data;
  logic [2*LANES-1:0]  pack_be;
  logic [LANES-1:0]    first_be_q;
  logic                done_q, err_q;
  logic [DATA_W-1:0]   rdata_q;

  // named events for assertions
  logic take, misaligned_req, fault_take, second_acc;

  lsu_mode_latch u_mode (
    .clk(clk), .rst_n(rst_n), .mode_i(boot_big_i),
    .big_o(big_q), .seen_o(mode_seen)
  );

  lsu_store_pack u_pack (
    .wdata_i(wdata_q), .off_i(off_q), .word_i(word_q), .big_i(big_q),
    .data_o(pack_data), .be_o(pack_be)
  );

  assign lo_sel = (state_q == S_WAIT2) ? lo_rd_q : mem_rdata_i;

  lsu_load_merge u_merge (
    .lo_i(lo_sel), .hi_i(mem_rdata_i), .off_i(off_q), .word_i(word_q),
    .big_i(big_q), .data_o(merged)
  );

  assign req_ready_o    = mode_seen && (state_q == S_IDLE);
  assign take           = req_valid_i && req_ready_o;
  assign misaligned_req = req_word_i && (req_addr_i[1:0] != 2'b00);
  assign fault_take     = take && misaligned_req && strict_align_i;
  assign second_acc     = (state_q == S_ISSUE2);
  assign widx_next      = widx_q + 1'b1;

  assign mem_req_o   = (state_q == S_ISSUE1) || second_acc;
  assign mem_we_o    = mem_req_o && write_q;
  assign mem_addr_o  = {(second_acc ? widx_next : widx_q), 2'b00};
  assign mem_be_o    = second_acc ? pack_be[2*LANES-1:LANES] : pack_be[LANES-1:0];
  assign mem_wdata_o = second_acc ? pack_data[2*DATA_W-1:DATA_W] : pack_data[DATA_W-1:0];

  assign done_o      = done_q;
  assign err_o       = err_q;
  assign load_data_o = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      write_q    <= 1'b0;
      word_q     <= 1'b0;
      split_q    <= 1'b0;
      off_q      <= '0;
      widx_q     <= '0;
      wdata_q    <= '0;
      lo_rd_q    <= '0;
      first_be_q <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      rdata_q    <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        S_IDLE: if (take) begin
          write_q <= req_write_i;
          word_q  <= req_word_i;
          off_q   <= req_addr_i[1:0];
          widx_q  <= req_addr_i[ADDR_W-1:2];
          wdata_q <= req_wdata_i;
          split_q <= misaligned_req;
          if (fault_take) begin
            done_q  <= 1'b1;
            err_q   <= 1'b1;
            rdata_q <= '0;
          end else begin
            state_q <= S_ISSUE1;
          end
        end
        S_ISSUE1: begin
          first_be_q <= mem_be_o;
          state_q    <= S_WAIT1;
        end
        S_WAIT1: if (mem_rvalid_i) begin
          lo_rd_q <= mem_rdata_i;
          if (split_q) begin
            state_q <= S_ISSUE2;
          end else begin
            done_q  <= 1'b1;
            rdata_q <= write_q ? '0 : merged;
            state_q <= S_IDLE;
          end
        end
        S_ISSUE2: state_q <= S_WAIT2;
        S_WAIT2: if (mem_rvalid_i) begin
          done_q  <= 1'b1;
          rdata_q <= write_q ? '0 : merged;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_fault_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_take |=> (done_o && err_o && !mem_req_o));
  p_err_with_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);
  p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE) |-> !req_ready_o);
  p_byte_one_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !word_q) |-> ($countones(mem_be_o) == 1));
  p_split_be_r9: assert property (@(posedge clk) disable iff (!rst_n)
    second_acc |-> (mem_be_o == ~first_be_q));
  p_aligned_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));
  p_done_after_resp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !err_o) |-> $past(mem_rvalid_i));
endmodule

// File: tb/endian_ldst_unit_bench.sv
module endian_ldst_unit_bench;
  localparam int AW = 6;
  localparam int NB = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic boot_big = 1'b0, strict = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, mem_req, mem_we, mem_rvalid, done, err;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, mem_rdata, load_data;

  logic [7:0] bmem [NB];
  logic [7:0] rmem [NB];
  int nacc = 0, cyc = 0, errors = 0, checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  endian_ldst_unit #(.ADDR_W(AW)) u_endian_ldst_unit (
    .clk(clk), .rst_n(rst_n), .boot_big_i(boot_big), .strict_align_i(strict),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_word_i(req_word),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_ready_o(req_ready),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_be_o(mem_be), .mem_wdata_o(mem_wdata), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .done_o(done), .err_o(err), .load_data_o(load_data)
  );

  function automatic logic [7:0] pat(int b);
    return 8'((b * 37 + 11) & 255);
  endfunction

  // one-cycle memory model, lane k = byte at mem_addr + k
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) bmem[b] <= pat(b);
    end else if (mem_req) begin
      nacc = nacc + 1;
      mem_rvalid <= 1'b1;
      for (int k = 0; k < 4; k++) begin
        mem_rdata[8*k +: 8] <= bmem[int'(mem_addr) + k];
        if (mem_we && mem_be[k]) bmem[int'(mem_addr) + k] <= mem_wdata[8*k +: 8];
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic w, input logic wd, input int a, input logic [31:0] v,
                        output logic [31:0] rd, output logic e, output int lat,
                        output int acc, output logic busy_rdy);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    nacc = 0;
    req_valid = 1'b1; req_write = w; req_word = wd;
    req_addr = AW'(a); req_wdata = v;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    busy_rdy = req_ready;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    rd = load_data; e = err; acc = nacc;
  endtask

  task automatic mem_cmp(string req);
    int bad = -1;
    for (int b = 0; b < NB; b++) if (bmem[b] !== rmem[b] && bad < 0) bad = b;
    if (bad >= 0) chk(0, req, 32'(bmem[bad]), 32'(rmem[bad]));
    else chk(1, req, 0, 0);
  endtask

  initial begin
    logic [31:0] rd, v, expv;
    logic e, brdy;
    int lat, acc;
    for (int run = 0; run < 4; run++) begin
      bit big = run[0];
      bit st  = run[1];
      rst_n = 1'b0; boot_big = big; strict = st;
      for (int b = 0; b < NB; b++) rmem[b] = pat(b);
      repeat (3) @(negedge clk);
      chk(done === 1'b0 && err === 1'b0 && mem_req === 1'b0, "R11 reset", {done, err, mem_req}, 0);
      rst_n = 1'b1;
      chk(req_ready === 1'b0, "R1 ready before sample", 32'(req_ready), 0);
      @(negedge clk);
      boot_big = ~big;   // R1: later strap changes must be ignored
      // R1 explicit: aligned word at 40
      run_op(1, 1, 40, 32'h12345678, rd, e, lat, acc, brdy);
      chk(bmem[40] == (big ? 8'h12 : 8'h78), "R1 latched order", 32'(bmem[40]), big ? 32'h12 : 32'h78);
      for (int i = 0; i < 4; i++) rmem[40 + i] = big ? 8'(32'h12345678 >> (8*(3-i))) : 8'(32'h12345678 >> (8*i));
      for (int a = 0; a < NB; a++) begin
        for (int wdi = 0; wdi < 2; wdi++) begin
          bit wd = wdi[0];
          bit mis = wd && (a % 4 != 0);
          bit flt = mis && st;
          int elat = flt ? 1 : (mis ? 5 : 3);
          int eacc = flt ? 0 : (mis ? 2 : 1);
          string sreq = flt ? "R7" : (mis ? "R9" : (wd ? (big ? "R3" : "R2") : "R4"));
          string lreq = flt ? "R7" : (mis ? "R10" : (wd ? (big ? "R3" : "R2") : "R5"));
          v = 32'h9E3779B9 * 32'(a * 4 + wdi * 2 + run + 1);
          // store
          run_op(1, wd, a, v, rd, e, lat, acc, brdy);
          if (!flt) begin
            for (int i = 0; i < (wd ? 4 : 1); i++)
              rmem[(a + i) % NB] = (wd && big) ? 8'(v >> (8*(3-i))) : 8'(v >> (8*i));
          end
          chk(e === flt, flt ? "R7 err" : "R11 no err", 32'(e), 32'(flt));
          chk(lat == elat, mis ? (flt ? "R7 latency" : "R8 latency") : "R6 latency", lat, elat);
          chk(acc == eacc, mis ? (flt ? "R7 no access" : "R8 two accesses") : "R6 one access", acc, eacc);
          if (!flt) chk(brdy === 1'b0, "R11 busy", 32'(brdy), 0);
          mem_cmp(sreq);
          // load back
          run_op(0, wd, a, 0, rd, e, lat, acc, brdy);
          expv = '0;
          for (int i = 0; i < (wd ? 4 : 1); i++)
            expv[((wd && big) ? (3 - i) : i) * 8 +: 8] = rmem[(a + i) % NB];
          chk(e === flt, "R7 load err", 32'(e), 32'(flt));
          chk(lat == elat, mis ? "R8 load latency" : "R6 load latency", lat, elat);
          chk(acc == eacc, mis ? "R8 load accesses" : "R6 load access", acc, eacc);
          if (!flt) chk(rd === expv, lreq, rd, expv);
          if (!flt && !mis && wd) chk(rd === v, big ? "R3 round trip" : "R2 round trip", rd, v);
        end
      end
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule